// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block holds a word of `WIDTH` stages that can be filled in one step from a parallel bus, or fed one bit at a time from a serial input. Its outputs are the last stage and the complement of the last stage. Stage 0 takes the serial bit, and data moves one stage toward the last stage on each shift. Devices can be chained into a longer serial converter: the true output of one device drives the serial input of the next.

Shifts are timed by a shift-clock pin and an active-low enable pin. The two pins are merged by an OR gate, so either pin can act as the clock and the other as the enable. A shift happens on a rising edge of that OR. The load input is active low and works on level. While it is low, the stages track the parallel bus and no shift takes place.

Every input belongs to one system clock domain. The inputs pass through `SYNC_STAGES` register stages before they are used. A rise of the merged clock is then detected against its previous sampled value. Because of this, releasing load while either pin is already high never causes a shift.

Top module: `piso_shifter`

## Requirements
- R1: While `loadN` is 0, the stages take the value of `parIn` (bit i into stage i), whatever `shiftClk` and `clkEnN` do. The last stage is `parIn[WIDTH-1]`.
- R2: While `loadN` is 1, each rising edge of (`shiftClk` OR `clkEnN`) moves every stage i to stage i+1 and puts `serIn` into stage 0. Nothing else changes the stages.
- R3: While `clkEnN` is 1, edges on `shiftClk` cause no shift.
- R4: A rise of `clkEnN` while `shiftClk` is 0 causes a shift, so the two pins can swap roles.
- R5: Releasing `loadN` (0 to 1) while `shiftClk` or `clkEnN` is 1 causes no shift.
- R6: When a load and a merged-clock rise arrive in the same sampled cycle, the load wins and no shift is applied.
- R7: `serOut` equals the last stage and `serOutN` is its inverse at every sample.
- R8: A clock edge with `rstN` at 0 clears all stages, so `serOut` reads 0 and `serOutN` reads 1. The sampled merged clock is held high during reset, so no shift follows the release of reset.
- R9: After `WIDTH` shifts, the serial bits appear at `serOut` in the order they entered. This lets a chain of devices work as one longer shifter.
- R10: A change on any input takes effect on the stages `SYNC_STAGES`+1 system clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous reset, active low |
| loadN | input | 1 | Parallel load, active low, level-sensitive |
| parIn | input | WIDTH | Parallel data, bit i goes to stage i |
| serIn | input | 1 | Serial data into stage 0 |
| shiftClk | input | 1 | Shift clock, ORed with clkEnN |
| clkEnN | input | 1 | Active-low clock enable, ORed with shiftClk |
| serOut | output | 1 | Last stage |
| serOutN | output | 1 | Inverse of last stage |

## Verification
The hardest case to reach is a merged-clock rise that must be ignored: a release of load while the clock pin is high, or clock toggles while the enable is high. Its effect only shows up in later output bits. The stimulus loads words chosen so that one wrong shift flips the last stage at once, such as 0x7F before a release with the clock high. It then checks the output before any legal shift occurs. The role swap is covered by raising the enable while the clock is low. A pattern of eight serial bits is pushed through to check the shift order.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // Strobes passed from control to datapath, one per system clock cycle
  typedef struct packed {
    logic load;   // copy parallel word into the stages
    logic shift;  // move stages one place toward the last stage
  } strobe_t;
endpackage

// File: rtl/piso_ctrl.sv
module piso_ctrl
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             clkEnN,
  output strobe_t          strobes,
  output logic [WIDTH-1:0] parBits,
  output logic             serBit
);
  localparam int BUS_W = WIDTH + 4;
  // bus layout: {serIn, clkEnN, shiftClk, loadN, parIn}
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b0, 1'b1, 1'b0, 1'b1, {WIDTH{1'b0}}};

  logic [BUS_W-1:0] rawBus;
  logic [BUS_W-1:0] pipe [SYNC_STAGES];
  logic [BUS_W-1:0] syncBus;
  logic             effSync;
  logic             effPrev;
  logic             loadSync;

  assign rawBus = {serIn, clkEnN, shiftClk, loadN, parIn};

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk) begin
        if (!rstN) pipe[g] <= BUS_IDLE;
        else if (g == 0) pipe[g] <= rawBus;
        else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign syncBus  = pipe[SYNC_STAGES-1];
  assign parBits  = syncBus[WIDTH-1:0];
  assign loadSync = ~syncBus[WIDTH];
  assign effSync  = syncBus[WIDTH+1] | syncBus[WIDTH+2];
  assign serBit   = syncBus[WIDTH+3];

  // previous merged clock; held high in reset so no edge appears on release
  always_ff @(posedge clk) begin
    if (!rstN) effPrev <= 1'b1;
    else       effPrev <= effSync;
  end

  always_comb begin
    strobes.load  = loadSync;
    strobes.shift = effSync & ~effPrev & ~loadSync;
  end

  // R3 / R5: a shift needs a low merged clock in the previous sampled cycle
  assert_shift_needs_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |-> $past(effSync) == 1'b0);
  // R6: never both strobes at once
  assert_load_priority_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.shift));
endmodule

// File: rtl/piso_datapath.sv
module piso_datapath
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [WIDTH-1:0] parBits,
  input  logic             serBit,
  output logic             lastStage
);
  logic [WIDTH-1:0] stageQ;

  always_ff @(posedge clk) begin
    if (!rstN)              stageQ <= '0;
    else if (strobes.load)  stageQ <= parBits;
    else if (strobes.shift) stageQ <= {stageQ[WIDTH-2:0], serBit};
  end

  assign lastStage = stageQ[WIDTH-1];

  assert_load_copy_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> stageQ == $past(parBits));
  assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && !strobes.load) |=>
      stageQ == {$past(stageQ[WIDTH-2:0]), $past(serBit)});
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shift && !strobes.load) |=> $stable(stageQ));
endmodule

// File: rtl/piso_shifter.sv
module piso_shifter
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadN,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serIn,
  input  logic             shiftClk,
  input  logic             clkEnN,
  output logic             serOut,
  output logic             serOutN
);
  strobe_t          strobes;
  logic [WIDTH-1:0] parBits;
  logic             serBit;
  logic             lastStage;

  piso_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .loadN(loadN), .parIn(parIn), .serIn(serIn),
    .shiftClk(shiftClk), .clkEnN(clkEnN),
    .strobes(strobes), .parBits(parBits), .serBit(serBit)
  );

  piso_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .parBits(parBits),
    .serBit(serBit), .lastStage(lastStage)
  );

  assign serOut  = lastStage;
  assign serOutN = ~lastStage;

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rstN |=> (serOut == 1'b0 && serOutN == 1'b1));
  assert_complement_R7: assert property (@(posedge clk) disable iff (!rstN)
    serOut != serOutN);
endmodule

// File: tb/piso_shifter_test.sv
module piso_shifter_test;
  localparam int W = 8;
  logic clk = 0, rstN = 0, loadN = 1, serIn = 0, shiftClk = 0, clkEnN = 0;
  logic [W-1:0] parIn = '0;
  logic serOut, serOutN;
  int runCnt = 0, failCnt = 0;

  always #2 clk = ~clk;

  piso_shifter #(.WIDTH(W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .parIn(parIn), .serIn(serIn),
    .shiftClk(shiftClk), .clkEnN(clkEnN), .serOut(serOut), .serOutN(serOutN));

  // row: {loadN, serIn, shiftClk, clkEnN, parIn[7:0], expected serOut}
  localparam int NV = 23;
  localparam logic [12:0] VEC [NV] = '{
    {4'b0000, 8'hA5, 1'b1},  // R1 load A5
    {4'b1000, 8'h00, 1'b1},  // R5 release, merged clock low
    {4'b1110, 8'h00, 1'b0},  // R2 shift in 1 -> 4B
    {4'b1100, 8'h00, 1'b0},  // R2 clock falls, hold
    {4'b1010, 8'h00, 1'b1},  // R2 shift in 0 -> 96
    {4'b1000, 8'h00, 1'b1},  // R2 hold
    {4'b1101, 8'h00, 1'b0},  // R4 enable rise shifts -> 2D
    {4'b1100, 8'h00, 1'b0},  // R4 enable falls
    {4'b1001, 8'h00, 1'b0},  // R4 enable rise shifts -> 5A
    {4'b1011, 8'h00, 1'b0},  // R3 clock rise with enable high ignored
    {4'b1001, 8'h00, 1'b0},  // R3 clock fall
    {4'b1000, 8'h00, 1'b0},  // R3 enable low again
    {4'b1010, 8'h00, 1'b1},  // R2 shift -> B4
    {4'b1000, 8'h00, 1'b1},  // R2 hold
    {4'b0010, 8'h7F, 1'b0},  // R1 load 7F with clock high
    {4'b1010, 8'h00, 1'b0},  // R5 release with clock high, no shift
    {4'b1000, 8'h00, 1'b0},  // R5 clock falls
    {4'b1010, 8'h00, 1'b1},  // R2 shift -> FE
    {4'b0000, 8'h80, 1'b1},  // R6 load 80
    {4'b0010, 8'h80, 1'b1},  // R6 clock rise during load ignored
    {4'b0000, 8'h80, 1'b1},  // R6 clock fall during load
    {4'b1000, 8'h00, 1'b1},  // R5 release, clock low
    {4'b1010, 8'h00, 1'b0}   // R2 shift -> 00
  };
  localparam string VREQ [NV] = '{
    "R1","R5","R2","R2","R2","R2","R4","R4","R4","R3","R3","R3",
    "R2","R2","R1","R5","R5","R2","R6","R6","R6","R5","R2"};

  task automatic check(input string req, input logic exp);
    runCnt++;
    if (serOut !== exp || serOutN !== ~exp) begin
      failCnt++;
      $display("FAIL %s: serOut=%b serOutN=%b expected %b/%b", req, serOut, serOutN, exp, ~exp);
    end
  endtask

  // drive at negedge, hold through SYNC_STAGES+1 edges plus margin, sample at negedge
  task automatic apply(input logic l, input logic s, input logic c, input logic e,
                       input logic [W-1:0] d);
    loadN = l; serIn = s; shiftClk = c; clkEnN = e; parIn = d;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    failCnt++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    logic [W-1:0] pat;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8", 1'b0);  // reset state
    rstN = 1;
    apply(1, 0, 0, 0, 8'h00);
    check("R8", 1'b0);  // no spurious shift after reset release

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:1]);
      check(VREQ[i], VEC[i][0]);
    end

    // R10: latency of SYNC_STAGES+1 edges for a load
    loadN = 0; parIn = 8'h80; shiftClk = 0; clkEnN = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R10", 1'b0);
    @(posedge clk); @(negedge clk);
    check("R10", 1'b1);
    apply(1, 0, 0, 0, 8'h00);

    // R9: serial entry order through all stages
    pat = 8'hC5;
    apply(0, 0, 0, 0, 8'h00);
    apply(1, 0, 0, 0, 8'h00);
    for (int k = W-1; k >= 0; k--) begin
      apply(1, pat[k], 1, 0, 8'h00);
      apply(1, pat[k], 0, 0, 8'h00);
    end
    for (int k = W-1; k >= 0; k--) begin
      check("R9", pat[k]);
      apply(1, 0, 1, 0, 8'h00);
      apply(1, 0, 0, 0, 8'h00);
    end

    // R8: reset mid-operation clears a loaded word
    apply(0, 0, 0, 0, 8'hFF);
    check("R7", 1'b1);
    rstN = 0;
    @(posedge clk); @(negedge clk);
    check("R8", 1'b0);
    loadN = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rstN = 1;
    apply(1, 0, 0, 0, 8'h00);
    check("R8", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule